// File: doc/BRIEF.md
# PLCP Framing Error Accumulator

This block watches the overhead at the head of each PLCP sub-frame (row) and counts framing errors. Each row opens with two alignment bytes and a path overhead identifier byte. The first alignment byte is marked by a row-start strobe, and the row index comes with that same strobe. The block checks each of these three bytes against its expected value. The expected identifier depends on the row index captured with the first alignment byte. A single byte comparator is shared by the three positions. A small row sequencer gathers the per-row mismatch totals. A counting stage then turns those totals into an increment, using the granularity chosen on the mode input.

Four counting granularities are available. The first counts out-of-frame onsets reported by the framer, with a rate limit. The other three count errored bits, errored bytes, or errored rows. The identifier byte can be left out of all comparisons by a control input. The running total is 16 bits wide and saturates. A latch strobe copies the running total into a holding register and restarts the count from zero, all in the same clock. An increment that arrives in the same cycle as the latch is kept.

The sequencer has three named states. SEEK waits for a row start. EXPECT_A2 waits for the second alignment byte. EXPECT_POI waits for the identifier byte. A valid byte with row-start moves the sequencer to EXPECT_A2 from any state, which is the transition named "restart". In EXPECT_A2, a valid byte without row-start moves it to EXPECT_POI ("advance"). In EXPECT_POI, a valid byte without row-start moves it back to SEEK and completes the row ("finish"). Valid bytes that arrive in SEEK without row-start are dropped ("skip").

Top module: `plcp_fe_acc`

## Requirements
- R1: After reset, `live_cnt` and `held_cnt` are both zero.
- R2: The expected values are F6h for the first alignment byte and 28h for the second. The expected identifier for row index 0 to 11 is, in order: 2Ch, 29h, 25h, 20h, 1Ch, 19h, 15h, 10h, 0Dh, 08h, 04h, 01h. The row index is sampled when `byte_vld` and `row_start` are both high, and it must be below 12 at that time.
- R3: With `mode` = 01 (bit granularity), each row adds the number of mismatched bits across its three checked bytes, at most 24 per row. The addition happens at the clock edge that accepts the identifier byte and shows on `live_cnt` in the next cycle.
- R4: With `mode` = 10 (byte granularity), each row adds the number of checked bytes that differ from their expected value, at most 3 per row.
- R5: With `mode` = 11 (row granularity), each row adds 1 if any checked byte differs from its expected value, and 0 otherwise.
- R6: With `poi_chk_en` low, the identifier byte is left out of the totals in the bit, byte and row granularities.
- R7: With `mode` = 00 (onset granularity), a pulse on `oof_onset` adds 1. After a counted onset, further onsets are ignored until three rows have completed. Row mismatches add nothing in this mode. Completed rows count toward that wait in every mode.
- R8: `live_cnt` never decreases except on a latch, and it saturates at FFFFh.
- R9: In a cycle with `latch` high, `held_cnt` takes the current `live_cnt` and `live_cnt` restarts from that cycle's increment. `held_cnt` does not change in any other cycle.
- R10: A row is the valid byte that carries `row_start`, followed by the next two valid bytes. If a new `row_start` arrives before the identifier byte, the open row is dropped without being counted, and the new row begins.
- R11: Cycles with `byte_vld` low, and valid bytes that arrive between a finished row and the next row start, leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_in | input | 8 | Received stream byte |
| byte_vld | input | 1 | `byte_in` holds a valid byte this cycle |
| row_start | input | 1 | Marks the first alignment byte of a row |
| row_idx | input | 4 | Row number 0 to 11, sampled with `row_start` |
| oof_onset | input | 1 | One-cycle pulse from the framer when out-of-frame begins |
| mode | input | 2 | Granularity: 00 onset, 01 bit, 10 byte, 11 row |
| poi_chk_en | input | 1 | Include the identifier byte in the checks |
| latch | input | 1 | Copy the count to `held_cnt` and restart the count |
| live_cnt | output | 16 | Running saturating error count |
| held_cnt | output | 16 | Count captured by the last latch |

## Verification
The assertions assume that `row_idx` names a real row whenever a row start is accepted. This assumption is itself checked. The stimulus only ever generates indices 0 to 11. The step-limit properties take the mode as sampled in the same cycle as the increment, so they stay valid even when the mode changes between rows. The bench changes mode and the identifier-check enable only while no row is open. The onset pulses it drives last a single cycle and fall in cycles with no row byte.

// File: rtl/plcp_fe_pkg.sv
package plcp_fe_pkg;

    localparam int BYTE_W    = 8;
    localparam int ROW_IDX_W = 4;
    localparam int NUM_ROWS  = 12;
    localparam int BYTES_PER_HDR = 3;
    localparam int BITS_W    = $clog2(BYTES_PER_HDR * BYTE_W + 1);
    localparam int BYTES_W   = $clog2(BYTES_PER_HDR + 1);
    localparam int ERR_W     = $clog2(BYTE_W + 1);

    localparam logic [BYTE_W-1:0] ALIGN_FIRST  = 8'hF6;
    localparam logic [BYTE_W-1:0] ALIGN_SECOND = 8'h28;

    typedef enum logic [1:0] {
        CNT_OOF  = 2'b00,
        CNT_BIT  = 2'b01,
        CNT_BYTE = 2'b10,
        CNT_WORD = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ST_SEEK       = 2'b00,
        ST_EXPECT_A2  = 2'b01,
        ST_EXPECT_POI = 2'b10
    } row_state_e;

    function automatic logic [BYTE_W-1:0] poi_expect(input logic [ROW_IDX_W-1:0] row);
        logic [BYTE_W-1:0] v;
        case (row)
            4'd0:    v = 8'h2C;
            4'd1:    v = 8'h29;
            4'd2:    v = 8'h25;
            4'd3:    v = 8'h20;
            4'd4:    v = 8'h1C;
            4'd5:    v = 8'h19;
            4'd6:    v = 8'h15;
            4'd7:    v = 8'h10;
            4'd8:    v = 8'h0D;
            4'd9:    v = 8'h08;
            4'd10:   v = 8'h04;
            4'd11:   v = 8'h01;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/plcp_fe_cmp.sv
module plcp_fe_cmp
    import plcp_fe_pkg::*;
#(
    parameter int W   = BYTE_W,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  rx_byte,
    input  logic [W-1:0]  exp_byte,
    input  logic          chk_en,
    output logic [CW-1:0] bit_errs,
    output logic          byte_err
);

    logic [W-1:0] diff;

    for (genvar g = 0; g < W; g++) begin : g_xor
        assign diff[g] = chk_en & (rx_byte[g] ^ exp_byte[g]);
    end

    always_comb begin
        bit_errs = '0;
        for (int i = 0; i < W; i++) begin
            bit_errs = bit_errs + CW'(diff[i]);
        end
    end

    assign byte_err = |diff;

endmodule

// File: rtl/plcp_fe_seq.sv
module plcp_fe_seq
    import plcp_fe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 byte_vld,
    input  logic                 row_start,
    input  logic [ROW_IDX_W-1:0] row_idx,
    input  logic                 poi_chk_en,
    input  logic [ERR_W-1:0]     bit_errs,
    input  logic                 byte_err,
    output logic [BYTE_W-1:0]    cmp_exp,
    output logic                 cmp_en,
    output logic                 row_done,
    output logic [BITS_W-1:0]    row_bits,
    output logic [BYTES_W-1:0]   row_bytes
);

    row_state_e            state_q, state_d;
    logic [ROW_IDX_W-1:0]  row_q;
    logic [BITS_W-1:0]     bit_acc_q;
    logic [BYTES_W-1:0]    byte_acc_q;
    logic                  take_first;
    logic                  take_mid;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEEK;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and per-byte outputs
    always_comb begin
        state_d    = state_q;
        cmp_exp    = ALIGN_FIRST;
        cmp_en     = 1'b1;
        row_done   = 1'b0;
        take_first = 1'b0;
        take_mid   = 1'b0;
        if (byte_vld && row_start) begin
            // restart: a row start always opens a fresh row
            take_first = 1'b1;
            state_d    = ST_EXPECT_A2;
        end else if (byte_vld) begin
            unique case (state_q)
                ST_SEEK: begin
                    // skip: stray byte between rows
                    state_d = ST_SEEK;
                    cmp_en  = 1'b0;
                end
                ST_EXPECT_A2: begin
                    // advance
                    cmp_exp  = ALIGN_SECOND;
                    take_mid = 1'b1;
                    state_d  = ST_EXPECT_POI;
                end
                ST_EXPECT_POI: begin
                    // finish
                    cmp_exp  = poi_expect(row_q);
                    cmp_en   = poi_chk_en;
                    row_done = 1'b1;
                    state_d  = ST_SEEK;
                end
                default: begin
                    cmp_en  = 1'b0;
                    state_d = ST_SEEK;
                end
            endcase
        end else begin
            cmp_en = 1'b0;
        end
    end

    // Row accumulators
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q      <= '0;
            bit_acc_q  <= '0;
            byte_acc_q <= '0;
        end else if (take_first) begin
            row_q      <= row_idx;
            bit_acc_q  <= BITS_W'(bit_errs);
            byte_acc_q <= BYTES_W'(byte_err);
        end else if (take_mid) begin
            bit_acc_q  <= bit_acc_q + BITS_W'(bit_errs);
            byte_acc_q <= byte_acc_q + BYTES_W'(byte_err);
        end
    end

    assign row_bits  = bit_acc_q + BITS_W'(bit_errs);
    assign row_bytes = byte_acc_q + BYTES_W'(byte_err);

endmodule

// File: rtl/plcp_fe_cnt.sv
module plcp_fe_cnt
    import plcp_fe_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int GUARD_ROWS = 3,
    localparam int GRD_W     = $clog2(GUARD_ROWS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cnt_mode_e          mode,
    input  logic               oof_onset,
    input  logic               row_done,
    input  logic [BITS_W-1:0]  row_bits,
    input  logic [BYTES_W-1:0] row_bytes,
    input  logic               latch,
    output logic [CNT_W-1:0]   live_cnt,
    output logic [CNT_W-1:0]   held_cnt
);

    logic [GRD_W-1:0]  guard_q;
    logic              oof_take;
    logic [BITS_W-1:0] inc;
    logic [CNT_W-1:0]  base;
    logic [CNT_W:0]    sum;

    assign oof_take = (mode == CNT_OOF) && oof_onset && (guard_q == '0);

    always_comb begin
        inc = '0;
        unique case (mode)
            CNT_OOF:  inc = BITS_W'(oof_take);
            CNT_BIT:  inc = row_done ? row_bits : '0;
            CNT_BYTE: inc = row_done ? BITS_W'(row_bytes) : '0;
            CNT_WORD: inc = BITS_W'(row_done && (row_bytes != '0));
            default:  inc = '0;
        endcase
    end

    assign base = latch ? '0 : live_cnt;
    assign sum  = {1'b0, base} + (CNT_W + 1)'(inc);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guard_q <= '0;
        end else if (oof_take) begin
            guard_q <= GRD_W'(GUARD_ROWS);
        end else if (row_done && (guard_q != '0)) begin
            guard_q <= guard_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_cnt <= '0;
            held_cnt <= '0;
        end else begin
            live_cnt <= sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
            if (latch) begin
                held_cnt <= live_cnt;
            end
        end
    end

endmodule

// File: rtl/plcp_fe_acc.sv
module plcp_fe_acc
    import plcp_fe_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int GUARD_ROWS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       byte_in,
    input  logic             byte_vld,
    input  logic             row_start,
    input  logic [3:0]       row_idx,
    input  logic             oof_onset,
    input  logic [1:0]       mode,
    input  logic             poi_chk_en,
    input  logic             latch,
    output logic [CNT_W-1:0] live_cnt,
    output logic [CNT_W-1:0] held_cnt
);

    logic [BYTE_W-1:0]  cmp_exp;
    logic               cmp_en;
    logic [ERR_W-1:0]   bit_errs;
    logic               byte_err;
    logic               row_done;
    logic [BITS_W-1:0]  row_bits;
    logic [BYTES_W-1:0] row_bytes;
    cnt_mode_e          mode_e;

    assign mode_e = cnt_mode_e'(mode);

    plcp_fe_cmp #(.W(BYTE_W)) u_cmp (
        .rx_byte  (byte_in),
        .exp_byte (cmp_exp),
        .chk_en   (cmp_en),
        .bit_errs (bit_errs),
        .byte_err (byte_err)
    );

    plcp_fe_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld   (byte_vld),
        .row_start  (row_start),
        .row_idx    (row_idx),
        .poi_chk_en (poi_chk_en),
        .bit_errs   (bit_errs),
        .byte_err   (byte_err),
        .cmp_exp    (cmp_exp),
        .cmp_en     (cmp_en),
        .row_done   (row_done),
        .row_bits   (row_bits),
        .row_bytes  (row_bytes)
    );

    plcp_fe_cnt #(.CNT_W(CNT_W), .GUARD_ROWS(GUARD_ROWS)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_e),
        .oof_onset (oof_onset),
        .row_done  (row_done),
        .row_bits  (row_bits),
        .row_bytes (row_bytes),
        .latch     (latch),
        .live_cnt  (live_cnt),
        .held_cnt  (held_cnt)
    );

endmodule

// File: rtl/plcp_fe_acc_chk.sv
module plcp_fe_acc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_vld,
    input logic             row_start,
    input logic [3:0]       row_idx,
    input logic             oof_onset,
    input logic [1:0]       mode,
    input logic             latch,
    input logic [CNT_W-1:0] live_cnt,
    input logic [CNT_W-1:0] held_cnt
);

    assert_row_idx_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && row_start) |-> (row_idx < 4'd12));

    assert_bit_step_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> (32'(live_cnt) <= 32'($past(live_cnt)) + 32'd24));

    assert_byte_step_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && !latch) |=> (32'(live_cnt) <= 32'($past(live_cnt)) + 32'd3));

    assert_word_step_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && !latch) |=> (32'(live_cnt) <= 32'($past(live_cnt)) + 32'd1));

    assert_oof_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !oof_onset && !latch) |=> $stable(live_cnt));

    assert_no_decrease_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> (live_cnt >= $past(live_cnt)));

    assert_saturate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == {CNT_W{1'b1}} && !latch) |=> (live_cnt == {CNT_W{1'b1}}));

    assert_latch_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> (held_cnt == $past(live_cnt)));

    assert_held_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(held_cnt));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && !byte_vld && !latch) |=> $stable(live_cnt));

endmodule

bind plcp_fe_acc plcp_fe_acc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .row_start (row_start),
    .row_idx   (row_idx),
    .oof_onset (oof_onset),
    .mode      (mode),
    .latch     (latch),
    .live_cnt  (live_cnt),
    .held_cnt  (held_cnt)
);

// File: tb/plcp_fe_acc_bench.sv
`timescale 1ns/1ps
module plcp_fe_acc_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  byte_in;
    logic        byte_vld;
    logic        row_start;
    logic [3:0]  row_idx;
    logic        oof_onset;
    logic [1:0]  mode;
    logic        poi_chk_en;
    logic        latch;
    logic [15:0] live_cnt;
    logic [15:0] held_cnt;

    always #4 clk = ~clk;

    plcp_fe_acc u_plcp_fe_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_in    (byte_in),
        .byte_vld   (byte_vld),
        .row_start  (row_start),
        .row_idx    (row_idx),
        .oof_onset  (oof_onset),
        .mode       (mode),
        .poi_chk_en (poi_chk_en),
        .latch      (latch),
        .live_cnt   (live_cnt),
        .held_cnt   (held_cnt)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    // reference model state
    int exp_live = 0;
    int exp_held = 0;
    int guard    = 0;
    int cur_row  = 0;
    int hdr[$];
    int poi_ref[12] = '{'h2C, 'h29, 'h25, 'h20, 'h1C, 'h19,
                        'h15, 'h10, 'h0D, 'h08, 'h04, 'h01};

    function automatic int nbits(int a, int b);
        logic [7:0] d;
        d = 8'(a ^ b);
        return $countones(d);
    endfunction

    task automatic model_step();
        int inc = 0;
        bit rowdone = 0;
        int bits = 0;
        int bytes = 0;
        int n;
        if (byte_vld && row_start) begin
            hdr.delete();
            hdr.push_back(int'(byte_in));
            cur_row = int'(row_idx);
        end else if (byte_vld && hdr.size() > 0) begin
            hdr.push_back(int'(byte_in));
            if (hdr.size() == 3) begin
                rowdone = 1;
                n = nbits(hdr[0], 'hF6); bits += n; if (n > 0) bytes++;
                n = nbits(hdr[1], 'h28); bits += n; if (n > 0) bytes++;
                if (poi_chk_en) begin
                    n = nbits(hdr[2], poi_ref[cur_row]); bits += n; if (n > 0) bytes++;
                end
                hdr.delete();
            end
        end
        case (mode)
            2'b00: if (oof_onset && guard == 0) inc = 1;
            2'b01: if (rowdone) inc = bits;
            2'b10: if (rowdone) inc = bytes;
            default: if (rowdone && bytes > 0) inc = 1;
        endcase
        if (mode == 2'b00 && oof_onset && guard == 0) guard = 3;
        else if (rowdone && guard > 0) guard--;
        if (latch) begin
            exp_held = exp_live;
            exp_live = 0;
        end
        exp_live += inc;
        if (exp_live > 65535) exp_live = 65535;
    endtask

    task automatic compare();
        n_cmp++;
        if (int'(live_cnt) != exp_live || int'(held_cnt) != exp_held) begin
            n_bad++;
            $display("FAIL %s: live=%0d held=%0d expected live=%0d held=%0d",
                     cur_req, live_cnt, held_cnt, exp_live, exp_held);
        end
    endtask

    task automatic expect_live(int v, string req);
        n_cmp++;
        if (int'(live_cnt) != v) begin
            n_bad++;
            $display("FAIL %s: live=%0d expected %0d", req, live_cnt, v);
        end
    endtask

    task automatic expect_held(int v, string req);
        n_cmp++;
        if (int'(held_cnt) != v) begin
            n_bad++;
            $display("FAIL %s: held=%0d expected %0d", req, held_cnt, v);
        end
    endtask

    task automatic cyc(input logic [7:0] b, input logic v, input logic rs,
                       input logic [3:0] ix, input logic oo, input logic la);
        byte_in   = b;
        byte_vld  = v;
        row_start = rs;
        row_idx   = ix;
        oof_onset = oo;
        latch     = la;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(8'h00, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0);
    endtask

    task automatic send_row(int ix, logic [7:0] a1x, logic [7:0] a2x, logic [7:0] px, int gap);
        cyc(8'hF6 ^ a1x, 1'b1, 1'b1, 4'(ix), 1'b0, 1'b0);
        idle(gap);
        cyc(8'h28 ^ a2x, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0);
        idle(gap);
        cyc(8'(poi_ref[ix]) ^ px, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0);
    endtask

    task automatic do_latch();
        cyc(8'h00, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; byte_in = '0; byte_vld = 0; row_start = 0; row_idx = '0;
        oof_onset = 0; mode = 2'b01; poi_chk_en = 1'b1; latch = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        compare();
        expect_live(0, "R1");
        expect_held(0, "R1");

        // R2: clean rows on every index count nothing
        cur_req = "R2";
        for (int r = 0; r < 12; r++) send_row(r, 8'h00, 8'h00, 8'h00, 0);
        expect_live(0, "R2");

        // R3: bit granularity, 1 + 2 + 1 mismatched bits
        cur_req = "R3";
        send_row(3, 8'h01, 8'h30, 8'h80, 0);
        expect_live(4, "R3");

        // R11: idle gaps inside a row, identifier fully wrong adds 8
        cur_req = "R11";
        send_row(7, 8'h00, 8'h00, 8'hFF, 2);
        expect_live(12, "R11");

        cur_req = "R9";
        do_latch();
        expect_held(12, "R9");
        expect_live(0, "R9");

        // R4: byte granularity, two errored bytes
        cur_req = "R4";
        mode = 2'b10;
        send_row(5, 8'hFF, 8'h00, 8'h01, 0);
        expect_live(2, "R4");

        // R5: row granularity
        cur_req = "R5";
        mode = 2'b11;
        send_row(0, 8'hFF, 8'hFF, 8'hFF, 0);
        expect_live(3, "R5");
        send_row(11, 8'h00, 8'h00, 8'h00, 0);
        expect_live(3, "R5");

        // R6: identifier check off
        cur_req = "R6";
        poi_chk_en = 1'b0;
        mode = 2'b01;
        send_row(9, 8'h00, 8'h00, 8'hFF, 0);
        expect_live(3, "R6");
        mode = 2'b11;
        send_row(4, 8'h00, 8'h00, 8'h55, 0);
        expect_live(3, "R6");
        poi_chk_en = 1'b1;

        // R10: restart before the identifier drops the open row
        cur_req = "R10";
        mode = 2'b01;
        cyc(8'h00, 1'b1, 1'b1, 4'd6, 1'b0, 1'b0);
        cyc(8'h00, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0);
        send_row(2, 8'h00, 8'h00, 8'h00, 0);
        expect_live(3, "R10");

        // R11: stray bytes between rows
        cur_req = "R11";
        for (int i = 0; i < 5; i++) cyc(8'(i * 37), 1'b1, 1'b0, 4'd0, 1'b0, 1'b0);
        expect_live(3, "R11");

        // R9: latch in the same cycle as the identifier byte
        cur_req = "R9";
        cyc(8'hF6 ^ 8'h03, 1'b1, 1'b1, 4'd8, 1'b0, 1'b0);
        cyc(8'h28, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0);
        cyc(8'h0D, 1'b1, 1'b0, 4'd0, 1'b0, 1'b1);
        expect_held(3, "R9");
        expect_live(2, "R9");

        // R7: onset granularity with three-row hold-off
        cur_req = "R7";
        mode = 2'b00;
        cyc(8'h00, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0);
        expect_live(3, "R7");
        cyc(8'h00, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0);
        expect_live(3, "R7");
        send_row(1, 8'hFF, 8'h00, 8'h00, 0);
        send_row(2, 8'h00, 8'h00, 8'h00, 0);
        cyc(8'h00, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0);
        expect_live(3, "R7");
        send_row(3, 8'h00, 8'h00, 8'h00, 0);
        cyc(8'h00, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0);
        expect_live(4, "R7");

        // R8: saturation
        cur_req = "R8";
        do_latch();
        mode = 2'b01;
        for (int k = 0; k < 2731; k++) send_row(k % 12, 8'hFF, 8'hFF, 8'hFF, 0);
        expect_live(65535, "R8");
        send_row(0, 8'hFF, 8'hFF, 8'hFF, 0);
        expect_live(65535, "R8");
        do_latch();
        expect_held(65535, "R8");
        expect_live(0, "R8");
        idle(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule